// File: doc/BRIEF.md
# Photodiode Array Scan Sequencer

This block runs the readout sequence for a linear photodiode array. A scan cycle opens with one readout that only clears the charge on the array and keeps no data. One or more readouts follow, and their pixels are offered to a FIFO write port. The gap between two readouts in a cycle is a host-set integration time. That time, and every other duration in the block, is counted in pixel-clock ticks, which arrive on a single-cycle tick input.

A cycle can start in four ways:
- from a rising edge of a host start bit;
- from a rising edge of an external trigger;
- from either edge of a chopper phase input;
- in continuous timer mode, with no trigger at all, where cycles restart back to back.

While a cycle runs, the block raises a running flag during each readout and pulses a start strobe toward the array at the beginning of each readout. It pulses an interrupt request when the cycle ends. In chopper operation, a flag reports whether the last cycle finished inside a single chopper phase. The external trigger level is mirrored back for the host to watch.

Top module: `pda_scan_seq`

## Requirements
- R1: A synchronous reset, active high, returns the block to idle. In the first clock after a reset edge, scanRun, readStart, fifoWrEn, cycleIrq, chopDone and extTrigSeen are all low. The reset also abandons a cycle that is in progress.
- R2: A cycle is one discard readout followed by max(storeCount,1) stored readouts, each lasting PIXELS pixel ticks. No FIFO write happens during the discard readout. With storeEn high, each stored readout writes exactly PIXELS words, one per pixel tick.
- R3: readStart is high for one clock at the first clock of every readout. With pixTick held high, consecutive readStart pulses within a cycle are PIXELS+integTicks clocks apart, and the last readStart of a cycle is followed by cycleIrq PIXELS clocks later.
- R4: With trigSel=0, a cycle starts on a 0-to-1 transition of swStart, and readStart rises one clock after swStart is first sampled high. Holding swStart high does not start another cycle.
- R5: scanRun is high only during readouts: for exactly PIXELS clocks per readout when pixTick is held high, and low during integration gaps and in idle. fifoWrEn is never high while scanRun is low.
- R6: With storeEn low, no FIFO write occurs. The readouts, scanRun and cycle timing are unchanged.
- R7: trigSel picks the start source: 0 = host bit, 1 = rising edge of extTrig, 2 = either edge of chopPhase, 3 = none. Events on the sources that are not selected start nothing.
- R8: With timerMode=2'b11, cycles restart on their own: the next readStart comes one clock after cycleIrq. Leaving this mode lets the running cycle finish, and no further cycle starts.
- R9: extTrigSeen equals the extTrig level of the previous clock.
- R10: chopDone is cleared on every chopPhase edge. In trigSel=2, chopDone is set at the end of a cycle only if no chopPhase edge occurred after that cycle started.
- R11: A start event that arrives while a cycle is running is ignored. It neither restarts nor extends the cycle.
- R12: cycleIrq is a single-clock pulse, raised in the clock after the last pixel of the final stored readout, when scanRun has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trigSel | input | 2 | Start source: 0 host, 1 external edge, 2 chopper, 3 none |
| timerMode | input | 2 | 2'b11 selects continuous cycling |
| storeEn | input | 1 | Allows readout data to be written to the FIFO |
| swStart | input | 1 | Host start bit, acts on its rising edge |
| extTrig | input | 1 | External trigger input |
| chopPhase | input | 1 | Chopper phase level (illuminated/dark) |
| pixTick | input | 1 | One-clock pulse per pixel clock |
| integTicks | input | INTEG_W | Integration gap in pixel ticks, latched at cycle start |
| storeCount | input | NREAD_W | Stored readouts per cycle (0 is taken as 1), latched at cycle start |
| scanRun | output | 1 | A readout is in progress |
| readStart | output | 1 | One-clock pulse at the start of each readout |
| fifoWrEn | output | 1 | FIFO write strobe, one per stored pixel |
| cycleIrq | output | 1 | One-clock end-of-cycle interrupt request |
| chopDone | output | 1 | Last cycle fitted inside one chopper phase |
| extTrigSeen | output | 1 | Registered copy of extTrig |

## Verification
The bench builds the sequencer with PIXELS=4, INTEG_W=3 and NREAD_W=3. With these widths, a whole cycle lasts at most a few dozen clocks, so one run can sweep every stored-readout count from 0 to 4 against every integration gap from 0 to 3, with storage both on and off. For each case, the bench compares write count, readout count, running time, readout spacing and cycle length against closed-form values. The same small size keeps the chopper and continuous-mode scenarios short enough to place phase edges before, during and after a cycle at exact clocks.

// File: rtl/pda_scan_pkg.sv
`timescale 1ns/1ps
package pda_scan_pkg;

  localparam logic [1:0] TRIG_HOST = 2'd0;
  localparam logic [1:0] TRIG_EXT  = 2'd1;
  localparam logic [1:0] TRIG_CHOP = 2'd2;
  localparam logic [1:0] TM_CONT   = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic start;      // begin cycle: latch config, zero index and counter
    logic enterRead;  // begin next readout: bump index, zero counter
    logic enterWait;  // begin integration gap: zero counter
    logic inRead;     // currently reading out
    logic inWait;     // currently integrating
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic readEnd;    // last pixel tick of a readout
    logic waitEnd;    // last tick of the integration gap
    logic integZero;  // latched gap is zero
    logic lastRead;   // current readout is the final one
    logic storeRead;  // current readout keeps data
  } dpStat_t;

endpackage

// File: rtl/pda_scan_dp.sv
`timescale 1ns/1ps
module pda_scan_dp
  import pda_scan_pkg::*;
#(
  parameter int PIXELS  = 256,
  parameter int INTEG_W = 16,
  parameter int NREAD_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strb,
  input  logic               pixTick,
  input  logic               storeEn,
  input  logic [INTEG_W-1:0] integTicks,
  input  logic [NREAD_W-1:0] storeCount,
  output dpStat_t            stat,
  output logic               fifoWrEn
);

  localparam int PIX_W = (PIXELS > 1) ? $clog2(PIXELS) : 1;
  localparam int CNT_W = (INTEG_W > PIX_W) ? INTEG_W : PIX_W;
  localparam logic [CNT_W-1:0] PIX_LAST = CNT_W'(PIXELS - 1);

  logic [CNT_W-1:0]   tickCnt;
  logic [NREAD_W-1:0] readIdx;
  logic [NREAD_W-1:0] lastIdx;
  logic [INTEG_W-1:0] integReg;
  logic [CNT_W-1:0]   integLast;

  assign integLast = CNT_W'(integReg) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt  <= '0;
      readIdx  <= '0;
      lastIdx  <= '0;
      integReg <= '0;
    end else if (strb.start) begin
      tickCnt  <= '0;
      readIdx  <= '0;
      integReg <= integTicks;
      lastIdx  <= (storeCount == '0) ? NREAD_W'(1) : storeCount;
    end else if (strb.enterRead) begin
      tickCnt <= '0;
      readIdx <= readIdx + 1'b1;
    end else if (strb.enterWait) begin
      tickCnt <= '0;
    end else if ((strb.inRead || strb.inWait) && pixTick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    stat.readEnd   = strb.inRead && pixTick && (tickCnt == PIX_LAST);
    stat.waitEnd   = strb.inWait && pixTick && (tickCnt == integLast);
    stat.integZero = (integReg == '0);
    stat.lastRead  = (readIdx == lastIdx);
    stat.storeRead = (readIdx != '0);
  end

  assign fifoWrEn = strb.inRead && pixTick && stat.storeRead && storeEn;

endmodule

// File: rtl/pda_scan_ctrl.sv
`timescale 1ns/1ps
module pda_scan_ctrl
  import pda_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] trigSel,
  input  logic [1:0] timerMode,
  input  logic       swStart,
  input  logic       extTrig,
  input  logic       chopPhase,
  input  dpStat_t    stat,
  output strobe_t    strb,
  output logic       scanRun,
  output logic       readStart,
  output logic       cycleIrq,
  output logic       chopDone,
  output logic       extTrigSeen
);

  seqState_t state, nxtState;
  logic swPrev, extPrev, phasePrev;
  logic swRise, extRise, phaseEdge;
  logic trigReq, startReq;
  logic goRead, endCycle;
  logic phaseClean;

  assign swRise    = swStart & ~swPrev;
  assign extRise   = extTrig & ~extPrev;
  assign phaseEdge = chopPhase ^ phasePrev;

  always_comb begin
    case (trigSel)
      TRIG_HOST: trigReq = swRise;
      TRIG_EXT:  trigReq = extRise;
      TRIG_CHOP: trigReq = phaseEdge;
      default:   trigReq = 1'b0;
    endcase
  end

  assign startReq = trigReq || (timerMode == TM_CONT);

  always_comb begin
    nxtState = state;
    strb     = '0;
    goRead   = 1'b0;
    endCycle = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          nxtState   = ST_READ;
          strb.start = 1'b1;
          goRead     = 1'b1;
        end
      end
      ST_READ: begin
        strb.inRead = 1'b1;
        if (stat.readEnd) begin
          if (stat.lastRead) begin
            nxtState = ST_IDLE;
            endCycle = 1'b1;
          end else if (stat.integZero) begin
            strb.enterRead = 1'b1;
            goRead         = 1'b1;
          end else begin
            nxtState       = ST_WAIT;
            strb.enterWait = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        strb.inWait = 1'b1;
        if (stat.waitEnd) begin
          nxtState       = ST_READ;
          strb.enterRead = 1'b1;
          goRead         = 1'b1;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      swPrev      <= 1'b0;
      extPrev     <= 1'b0;
      phasePrev   <= 1'b0;
      readStart   <= 1'b0;
      cycleIrq    <= 1'b0;
      phaseClean  <= 1'b0;
      chopDone    <= 1'b0;
      extTrigSeen <= 1'b0;
    end else begin
      state       <= nxtState;
      swPrev      <= swStart;
      extPrev     <= extTrig;
      phasePrev   <= chopPhase;
      readStart   <= goRead;
      cycleIrq    <= endCycle;
      extTrigSeen <= extTrig;
      if (strb.start)     phaseClean <= 1'b1;
      else if (phaseEdge) phaseClean <= 1'b0;
      if (phaseEdge)                                chopDone <= 1'b0;
      else if (endCycle && (trigSel == TRIG_CHOP))  chopDone <= phaseClean;
    end
  end

  assign scanRun = (state == ST_READ);

endmodule

// File: rtl/pda_scan_seq.sv
`timescale 1ns/1ps
module pda_scan_seq
  import pda_scan_pkg::*;
#(
  parameter int PIXELS  = 256,
  parameter int INTEG_W = 16,
  parameter int NREAD_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         trigSel,
  input  logic [1:0]         timerMode,
  input  logic               storeEn,
  input  logic               swStart,
  input  logic               extTrig,
  input  logic               chopPhase,
  input  logic               pixTick,
  input  logic [INTEG_W-1:0] integTicks,
  input  logic [NREAD_W-1:0] storeCount,
  output logic               scanRun,
  output logic               readStart,
  output logic               fifoWrEn,
  output logic               cycleIrq,
  output logic               chopDone,
  output logic               extTrigSeen
);

  strobe_t strb;
  dpStat_t stat;

  pda_scan_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .trigSel    (trigSel),
    .timerMode  (timerMode),
    .swStart    (swStart),
    .extTrig    (extTrig),
    .chopPhase  (chopPhase),
    .stat       (stat),
    .strb       (strb),
    .scanRun    (scanRun),
    .readStart  (readStart),
    .cycleIrq   (cycleIrq),
    .chopDone   (chopDone),
    .extTrigSeen(extTrigSeen)
  );

  pda_scan_dp #(
    .PIXELS (PIXELS),
    .INTEG_W(INTEG_W),
    .NREAD_W(NREAD_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .pixTick   (pixTick),
    .storeEn   (storeEn),
    .integTicks(integTicks),
    .storeCount(storeCount),
    .stat      (stat),
    .fifoWrEn  (fifoWrEn)
  );

endmodule

// File: rtl/pda_scan_chk.sv
`timescale 1ns/1ps
module pda_scan_chk (
  input logic clk,
  input logic rst,
  input logic storeEn,
  input logic scanRun,
  input logic readStart,
  input logic fifoWrEn,
  input logic cycleIrq
);

  AST_START_IN_READ: assert property (@(posedge clk) disable iff (rst)
    readStart |-> scanRun);                                   // R3

  AST_WRITE_IN_READ: assert property (@(posedge clk) disable iff (rst)
    fifoWrEn |-> scanRun);                                    // R5

  AST_NO_STORE_OFF: assert property (@(posedge clk) disable iff (rst)
    !storeEn |-> !fifoWrEn);                                  // R6

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cycleIrq |=> !cycleIrq);                                  // R12

  AST_IRQ_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    cycleIrq |-> (!scanRun && $past(scanRun)));               // R12

endmodule

bind pda_scan_seq pda_scan_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .storeEn  (storeEn),
  .scanRun  (scanRun),
  .readStart(readStart),
  .fifoWrEn (fifoWrEn),
  .cycleIrq (cycleIrq)
);

// File: tb/test_pda_scan_seq.sv
`timescale 1ns/1ps
module test_pda_scan_seq;

  localparam int P  = 4;
  localparam int IW = 3;
  localparam int NW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] trigSel = 2'd0;
  logic [1:0] timerMode = 2'd0;
  logic storeEn = 1'b0;
  logic swStart = 1'b0;
  logic extTrig = 1'b0;
  logic chopPhase = 1'b0;
  logic pixTick = 1'b1;
  logic [IW-1:0] integTicks = '0;
  logic [NW-1:0] storeCount = '0;
  logic scanRun, readStart, fifoWrEn, cycleIrq, chopDone, extTrigSeen;

  pda_scan_seq #(.PIXELS(P), .INTEG_W(IW), .NREAD_W(NW)) i_pda_scan_seq (
    .clk(clk), .rst(rst), .trigSel(trigSel), .timerMode(timerMode),
    .storeEn(storeEn), .swStart(swStart), .extTrig(extTrig),
    .chopPhase(chopPhase), .pixTick(pixTick), .integTicks(integTicks),
    .storeCount(storeCount), .scanRun(scanRun), .readStart(readStart),
    .fifoWrEn(fifoWrEn), .cycleIrq(cycleIrq), .chopDone(chopDone),
    .extTrigSeen(extTrigSeen)
  );

  always #2 clk = ~clk;  // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic slowTick = 1'b0;
  always @(negedge clk) pixTick <= slowTick ? ~pixTick : 1'b1;

  int nChecks = 0, nFail = 0;
  int nStart, nWrite, nRun, nIrq, discWr, spErr, idxInCyc;
  int firstStartCyc, lastStartCyc, lastIrqCyc, expGap;
  bit gapChk = 1'b1;

  always @(negedge clk) if (!rst) begin
    if (readStart) begin
      if (idxInCyc > 0 && gapChk && (cyc - lastStartCyc) != expGap) spErr++;
      if (idxInCyc == 0) firstStartCyc = cyc;
      lastStartCyc = cyc;
      idxInCyc++;
      nStart++;
    end
    if (fifoWrEn) begin
      nWrite++;
      if (idxInCyc == 1) discWr++;
    end
    if (scanRun) nRun++;
    if (cycleIrq) begin
      nIrq++;
      lastIrqCyc = cyc;
      idxInCyc = 0;
    end
  end

  task automatic clearMon();
    nStart = 0; nWrite = 0; nRun = 0; nIrq = 0; discWr = 0; spErr = 0;
    idxInCyc = 0; firstStartCyc = 0; lastStartCyc = 0; lastIrqCyc = 0;
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic waitIrq(input string req);
    int k;
    for (k = 0; k < 400; k++) begin
      tick();
      if (cycleIrq) break;
    end
    if (k == 400) chk({req, " irq timeout"}, 0, 1);
  endtask

  task automatic pulseSw();
    swStart = 1'b1;
    tick();
    swStart = 1'b0;
  endtask

  task automatic checkIdle(input string req);
    chk({req, " scanRun"}, int'(scanRun), 0);
    chk({req, " readStart"}, int'(readStart), 0);
    chk({req, " fifoWrEn"}, int'(fifoWrEn), 0);
    chk({req, " cycleIrq"}, int'(cycleIrq), 0);
    chk({req, " chopDone"}, int'(chopDone), 0);
    chk({req, " extTrigSeen"}, int'(extTrigSeen), 0);
  endtask

  initial begin
    #(4 * 190000);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    clearMon();
    tick(4);
    checkIdle("R1 reset");
    rst = 1'b0;
    tick(3);
    checkIdle("R1 after release");

    // R2 R3 R5 R6 sweep over stored count, gap and store enable
    for (int se = 0; se < 2; se++)
      for (int n = 0; n < 5; n++)
        for (int i = 0; i < 4; i++) begin
          automatic int ne = (n == 0) ? 1 : n;
          storeCount = NW'(n);
          integTicks = IW'(i);
          storeEn = se[0];
          expGap = P + i;
          clearMon();
          pulseSw();
          waitIrq("R2");
          tick();
          chk("R2 writes", nWrite, se * P * ne);
          chk("R2 discard readout writes", discWr, 0);
          chk("R2 readouts", nStart, ne + 1);
          chk("R5 run clocks", nRun, (ne + 1) * P);
          chk("R3 spacing errors", spErr, 0);
          chk("R3 cycle length", lastIrqCyc - firstStartCyc, (ne + 1) * P + ne * i);
          chk("R12 irq count", nIrq, 1);
          if (se == 0) chk("R6 no writes", nWrite, 0);
        end

    // R4 level held does not restart
    storeCount = NW'(1); integTicks = '0; storeEn = 1'b1; expGap = P;
    clearMon();
    swStart = 1'b1;
    tick();
    chk("R4 start on rise", int'(readStart), 1);
    waitIrq("R4");
    tick(30);
    chk("R4 held level no restart", nStart, 2);
    swStart = 1'b0; tick();
    swStart = 1'b1; tick();
    chk("R4 new rise restarts", int'(readStart), 1);
    swStart = 1'b0;
    waitIrq("R4"); tick();

    // R11 start during a running cycle is ignored
    storeCount = NW'(2); integTicks = IW'(2); expGap = P + 2;
    clearMon();
    pulseSw();
    tick(3);
    pulseSw();
    tick(5);
    pulseSw();
    waitIrq("R11"); tick(30);
    chk("R11 readouts", nStart, 3);
    chk("R11 irq count", nIrq, 1);
    chk("R11 cycle length", lastIrqCyc - firstStartCyc, 3 * P + 2 * 2);

    // R9 trigger mirror
    begin
      automatic logic [4:0] pat = 5'b01101;
      for (int k = 0; k < 5; k++) begin
        extTrig = pat[k];
        tick();
        chk("R9 mirror", int'(extTrigSeen), int'(pat[k]));
      end
      extTrig = 1'b0; tick();
    end

    // R7 source selection
    storeCount = NW'(1); integTicks = '0; expGap = P;
    trigSel = 2'd1;
    clearMon();
    pulseSw(); chopPhase = ~chopPhase; tick(20);
    chk("R7 ext mode ignores host and phase", nStart, 0);
    extTrig = 1'b1; tick();
    chk("R7 ext rise starts", int'(readStart), 1);
    waitIrq("R7"); tick();
    extTrig = 1'b0; tick(30);
    chk("R7 ext fall no start", nStart, 2);
    trigSel = 2'd3;
    clearMon();
    extTrig = 1'b1; pulseSw(); chopPhase = ~chopPhase; tick(30);
    chk("R7 none selected", nStart, 0);
    extTrig = 1'b0;
    trigSel = 2'd2;
    tick(2);
    clearMon();
    extTrig = 1'b1; pulseSw(); tick(20);
    chk("R7 chop mode ignores ext and host", nStart, 0);
    extTrig = 1'b0; tick();

    // R10 chopper completion flag; cycle is 2*P+2 clocks
    integTicks = IW'(2); expGap = P + 2;
    chopPhase = ~chopPhase; tick();
    chk("R7 phase edge starts", int'(readStart), 1);
    chk("R10 cleared on edge", int'(chopDone), 0);
    waitIrq("R10"); tick();
    chk("R10 set when cycle fits", int'(chopDone), 1);
    chopPhase = ~chopPhase; tick();
    chk("R10 cleared at next edge", int'(chopDone), 0);
    tick(3);
    chopPhase = ~chopPhase;
    waitIrq("R10"); tick();
    chk("R10 stays clear when edge inside cycle", int'(chopDone), 0);
    chopPhase = ~chopPhase; tick();
    waitIrq("R10"); tick();
    chk("R10 set again", int'(chopDone), 1);

    // R8 continuous timer mode; cycle 2*P+1 clocks
    trigSel = 2'd0; integTicks = IW'(1); expGap = P + 1;
    clearMon();
    timerMode = 2'b11;
    for (int k = 0; k < 3; k++) begin
      waitIrq("R8");
      chk("R8 no start on irq clock", int'(readStart), 0);
      tick();
      chk("R8 restart next clock", int'(readStart), 1);
    end
    timerMode = 2'd0;
    waitIrq("R8"); tick(30);
    chk("R8 stops after mode cleared", nStart, 8);
    chk("R8 idle after stop", int'(scanRun), 0);
    chk("R3 continuous spacing errors", spErr, 0);

    // R2 with pixel ticks on every other clock
    slowTick = 1'b1; gapChk = 1'b0;
    storeCount = NW'(2); integTicks = IW'(3);
    tick(2);
    clearMon();
    pulseSw();
    waitIrq("R2 slow"); tick();
    chk("R2 slow writes", nWrite, 2 * P);
    chk("R2 slow readouts", nStart, 3);
    chk("R2 slow discard writes", discWr, 0);
    slowTick = 1'b0; gapChk = 1'b1;
    tick(2);

    // R1 reset in the middle of a cycle, with chopDone still set
    chk("R1 chopDone set before reset", int'(chopDone), 1);
    storeEn = 1'b1;
    clearMon();
    pulseSw();
    tick(P + 1);
    extTrig = 1'b1;
    rst = 1'b1;
    tick();
    checkIdle("R1 mid-cycle reset");
    extTrig = 1'b0;
    rst = 1'b0;
    tick(40);
    chk("R1 no activity after reset", int'(scanRun) + int'(fifoWrEn), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule